// File: doc/BRIEF.md
# SPI Register Access Engine

This block is a mode-0 SPI master for a sensor whose register protocol frames every access in bytes: a two-byte header carrying the direction flag and a split 8-bit address, then one data byte for a write, or one to eight returned bytes for a read. A host hands it one command at a time over a request/acknowledge port: direction, address, write data and a 3-bit burst length coded as count minus one. The engine then drops chip select, clocks the whole frame, and raises chip select again.

The header puts the direction flag in the top bit of the first byte, with 1 meaning write, and address bits 6 to 0 below it. The second byte carries address bit 7 in its top bit and zeros in the other seven places. During a read the engine shifts out zeros after the header and captures each MISO byte MSB first. Every byte it captures appears as a one-cycle pulse on a valid/data output. The slave advances its own address, so a burst needs nothing more than extra groups of eight clocks.

The SCLK rate is fixed at build time as the system clock divided by (PRE+1)·2^(EXP+1). Between two frames chip select stays high for at least one full SCLK period.

Top module: `spi_regbus_master`

## Requirements
- R1: After reset, chip select is high, SCLK and MOSI are low, the command port is ready and no read byte is valid.
- R2: SCLK is low whenever chip select is high. MOSI changes only while SCLK is low, so it is stable across each rising edge, where the slave samples it.
- R3: One SCLK period lasts 2·(DIV_PRE+1)·2^DIV_EXP system clocks, which is 4 clocks with the defaults DIV_PRE=1 and DIV_EXP=0.
- R4: The first byte on MOSI is {dir, addr[6:0]}, where dir is 1 for a write and 0 for a read, sent MSB first.
- R5: The second byte on MOSI is {addr[7], 7'b0000000}.
- R6: A write frame has exactly 24 SCLK rising edges, and its third byte is the write data, sent MSB first.
- R7: A read frame with length field L has exactly 8·(3+L) SCLK rising edges, so it carries L+1 data bytes, and MOSI is zero during every data byte.
- R8: Each byte read from MISO is assembled MSB first and produced as a single one-cycle rd_valid pulse while chip select is still low. The bytes come out in arrival order, L+1 of them per read and none per write.
- R9: cmd_ready is high only while the engine is idle. The cycle after a command is accepted, cmd_ready is low and chip select is low.
- R10: Chip select stays high for at least one full SCLK period between the end of one frame and the start of the next.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Command acknowledge; high while idle |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | 8 | Register address |
| cmd_wdata | input | 8 | Write data |
| cmd_len | input | 3 | Read burst length minus one |
| rd_valid | output | 1 | One-cycle pulse per received byte |
| rd_data | output | 8 | Received byte |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to the slave |
| spi_miso | input | 1 | Serial data from the slave |
| spi_cs_n | output | 1 | Active-low chip select |

## Verification
On every cycle the assertions check these properties: SCLK stays low while chip select is high, MOSI holds still while SCLK is high, and the command handshake behaves as specified. They also check that each frame closes after a whole number of bytes of at least 24 edges, that chip select stays high for a full period between frames, and that read pulses are isolated and fall inside a frame. Only the bench scenarios can show the values involved. These are the bit placement of the header and write bytes (a write of 0x3D to 0x3A and an address with bit 7 set), the ID byte 0x6A captured from register 0x0D, burst contents across address wrap-around, and the measured SCLK period.

// File: rtl/spi_regbus_pkg.sv
`timescale 1ns/1ps
package spi_regbus_pkg;

    localparam int unsigned REG_ADDR_W = 8;
    localparam int unsigned REG_DATA_W = 8;
    localparam int unsigned BURST_W    = 3;
    localparam int unsigned HDR_BYTES  = 2;
    localparam int unsigned MAX_BYTES  = HDR_BYTES + (1 << BURST_W);
    localparam int unsigned IDX_W      = $clog2(MAX_BYTES);
    localparam int unsigned BIT_W      = $clog2(REG_DATA_W);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_XFER,
        ST_TAIL,
        ST_GAP
    } xfer_st_e;

    typedef struct packed {
        logic                  write;
        logic [REG_ADDR_W-1:0] addr;
        logic [REG_DATA_W-1:0] wdata;
        logic [BURST_W-1:0]    len;
    } reg_cmd_t;

endpackage

// File: rtl/spi_sclk_divider.sv
`timescale 1ns/1ps
module spi_sclk_divider #(
    parameter int unsigned HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int unsigned CNT_W = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CNT_W-1:0] TOP = CNT_W'(HALF - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = run && (cnt_q == TOP);
        cnt_d = cnt_q;
        if (!run || tick) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/spi_frame_mux.sv
`timescale 1ns/1ps
module spi_frame_mux
    import spi_regbus_pkg::*;
(
    input  reg_cmd_t               cmd,
    input  logic [IDX_W-1:0]       idx,
    output logic [REG_DATA_W-1:0]  tx_byte,
    output logic [IDX_W-1:0]       last_idx
);
    localparam logic [IDX_W-1:0] IDX_DATA = IDX_W'(HDR_BYTES);

    always_comb begin
        tx_byte = '0;
        if (idx == '0) begin
            tx_byte = {cmd.write, cmd.addr[REG_ADDR_W-2:0]};
        end else if (idx == IDX_W'(1)) begin
            tx_byte = {cmd.addr[REG_ADDR_W-1], {(REG_DATA_W-1){1'b0}}};
        end else if (cmd.write && idx == IDX_DATA) begin
            tx_byte = cmd.wdata;
        end

        if (cmd.write) begin
            last_idx = IDX_DATA;
        end else begin
            last_idx = IDX_DATA + IDX_W'(cmd.len);
        end
    end
endmodule

// File: rtl/spi_regbus_fsm.sv
`timescale 1ns/1ps
module spi_regbus_fsm
    import spi_regbus_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmd_valid,
    input  reg_cmd_t              cmd_in,
    output logic                  cmd_ready,
    input  logic                  tick,
    output logic                  run,
    output reg_cmd_t              frame_cmd,
    output logic [IDX_W-1:0]      frame_idx,
    input  logic [REG_DATA_W-1:0] frame_byte,
    input  logic [IDX_W-1:0]      frame_last,
    input  logic                  miso,
    output logic                  sclk,
    output logic                  mosi,
    output logic                  cs_n,
    output logic                  rd_valid,
    output logic [REG_DATA_W-1:0] rd_data
);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(REG_DATA_W - 1);
    localparam logic [IDX_W-1:0] IDX_DATA = IDX_W'(HDR_BYTES);

    typedef struct packed {
        xfer_st_e              st;
        reg_cmd_t              cmd;
        logic [IDX_W-1:0]      byte_idx;
        logic [BIT_W-1:0]      bit_idx;
        logic [REG_DATA_W-1:0] tx;
        logic [REG_DATA_W-1:0] rx;
        logic                  sclk;
        logic                  mosi;
        logic                  cs_n;
        logic                  rv;
        logic [REG_DATA_W-1:0] rdata;
        logic                  gap;
    } fsm_t;

    localparam fsm_t FSM_RST = '{
        st:       ST_IDLE,
        cmd:      '0,
        byte_idx: '0,
        bit_idx:  '0,
        tx:       '0,
        rx:       '0,
        sclk:     1'b0,
        mosi:     1'b0,
        cs_n:     1'b1,
        rv:       1'b0,
        rdata:    '0,
        gap:      1'b0
    };

    fsm_t q, d;
    logic idle;

    assign idle      = (q.st == ST_IDLE);
    assign cmd_ready = idle;
    assign run       = !idle;
    assign frame_cmd = idle ? cmd_in : q.cmd;
    assign frame_idx = idle ? '0 : q.byte_idx + 1'b1;

    always_comb begin
        d    = q;
        d.rv = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (cmd_valid) begin
                    d.st       = ST_XFER;
                    d.cmd      = cmd_in;
                    d.byte_idx = '0;
                    d.bit_idx  = '0;
                    d.tx       = frame_byte;
                    d.mosi     = frame_byte[REG_DATA_W-1];
                    d.sclk     = 1'b0;
                    d.cs_n     = 1'b0;
                end
            end
            ST_XFER: begin
                if (tick) begin
                    if (!q.sclk) begin
                        d.sclk = 1'b1;
                        d.rx   = {q.rx[REG_DATA_W-2:0], miso};
                    end else begin
                        d.sclk = 1'b0;
                        if (q.bit_idx == BIT_LAST) begin
                            if (!q.cmd.write && q.byte_idx >= IDX_DATA) begin
                                d.rv    = 1'b1;
                                d.rdata = q.rx;
                            end
                            d.bit_idx = '0;
                            if (q.byte_idx == frame_last) begin
                                d.st   = ST_TAIL;
                                d.mosi = 1'b0;
                            end else begin
                                d.byte_idx = q.byte_idx + 1'b1;
                                d.tx       = frame_byte;
                                d.mosi     = frame_byte[REG_DATA_W-1];
                            end
                        end else begin
                            d.bit_idx = q.bit_idx + 1'b1;
                            d.tx      = {q.tx[REG_DATA_W-2:0], 1'b0};
                            d.mosi    = q.tx[REG_DATA_W-2];
                        end
                    end
                end
            end
            ST_TAIL: begin
                if (tick) begin
                    d.cs_n = 1'b1;
                    d.st   = ST_GAP;
                    d.gap  = 1'b0;
                end
            end
            ST_GAP: begin
                if (tick) begin
                    if (q.gap) begin
                        d.st = ST_IDLE;
                    end else begin
                        d.gap = 1'b1;
                    end
                end
            end
            default: d = FSM_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= FSM_RST;
        end else begin
            q <= d;
        end
    end

    assign sclk     = q.sclk;
    assign mosi     = q.mosi;
    assign cs_n     = q.cs_n;
    assign rd_valid = q.rv;
    assign rd_data  = q.rdata;
endmodule

// File: rtl/spi_regbus_master.sv
`timescale 1ns/1ps
module spi_regbus_master
    import spi_regbus_pkg::*;
#(
    parameter int unsigned DIV_PRE = 1,
    parameter int unsigned DIV_EXP = 0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmd_valid,
    output logic                  cmd_ready,
    input  logic                  cmd_write,
    input  logic [REG_ADDR_W-1:0] cmd_addr,
    input  logic [REG_DATA_W-1:0] cmd_wdata,
    input  logic [BURST_W-1:0]    cmd_len,
    output logic                  rd_valid,
    output logic [REG_DATA_W-1:0] rd_data,
    output logic                  spi_sclk,
    output logic                  spi_mosi,
    input  logic                  spi_miso,
    output logic                  spi_cs_n
);
    localparam int unsigned SCLK_HALF = (DIV_PRE + 1) * (2 ** DIV_EXP);

    reg_cmd_t              cmd_in;
    reg_cmd_t              frame_cmd;
    logic [IDX_W-1:0]      frame_idx;
    logic [IDX_W-1:0]      frame_last;
    logic [REG_DATA_W-1:0] frame_byte;
    logic                  tick;
    logic                  run;

    assign cmd_in = '{write: cmd_write, addr: cmd_addr, wdata: cmd_wdata, len: cmd_len};

    spi_sclk_divider #(.HALF(SCLK_HALF)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick)
    );

    spi_frame_mux u_mux (
        .cmd      (frame_cmd),
        .idx      (frame_idx),
        .tx_byte  (frame_byte),
        .last_idx (frame_last)
    );

    spi_regbus_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_in     (cmd_in),
        .cmd_ready  (cmd_ready),
        .tick       (tick),
        .run        (run),
        .frame_cmd  (frame_cmd),
        .frame_idx  (frame_idx),
        .frame_byte (frame_byte),
        .frame_last (frame_last),
        .miso       (spi_miso),
        .sclk       (spi_sclk),
        .mosi       (spi_mosi),
        .cs_n       (spi_cs_n),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data)
    );
endmodule

// File: rtl/spi_regbus_checker.sv
`timescale 1ns/1ps
module spi_regbus_checker #(
    parameter int unsigned SCLK_HALF = 2
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic       cmd_ready,
    input logic       rd_valid,
    input logic       spi_sclk,
    input logic       spi_mosi,
    input logic       spi_cs_n
);
    logic [7:0]  edge_cnt_q;
    logic        sclk_prev_q;
    logic [15:0] high_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            edge_cnt_q  <= '0;
            sclk_prev_q <= 1'b0;
            high_cnt_q  <= '1;
        end else begin
            sclk_prev_q <= spi_sclk;
            if (spi_cs_n) begin
                edge_cnt_q <= '0;
                if (high_cnt_q != '1) high_cnt_q <= high_cnt_q + 1'b1;
            end else begin
                high_cnt_q <= '0;
                if (spi_sclk && !sclk_prev_q) edge_cnt_q <= edge_cnt_q + 1'b1;
            end
        end
    end

    // R2
    sclk_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sclk);

    // R2
    mosi_hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_sclk && !spi_cs_n) |=> (!spi_sclk || $stable(spi_mosi)));

    // R9
    ready_only_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> spi_cs_n);

    // R9
    accept_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> (!cmd_ready && !spi_cs_n));

    // R6 R7
    whole_bytes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_cs_n) |-> (edge_cnt_q[2:0] == 3'd0 && edge_cnt_q >= 8'd24));

    // R10
    cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spi_cs_n) |-> (high_cnt_q >= 16'(2 * SCLK_HALF)));

    // R8
    rd_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !spi_cs_n);

    // R8
    rd_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);
endmodule

bind spi_regbus_master spi_regbus_checker #(.SCLK_HALF(SCLK_HALF)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .rd_valid  (rd_valid),
    .spi_sclk  (spi_sclk),
    .spi_mosi  (spi_mosi),
    .spi_cs_n  (spi_cs_n)
);

// File: tb/sim_spi_regbus_master.sv
`timescale 1ns/1ps
module sim_spi_regbus_master;
    localparam int PRE = 1;
    localparam int EXP = 0;
    localparam int PERIOD_CLKS = 2 * (PRE + 1) * (2 ** EXP);

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic       cmd_ready;
    logic       cmd_write = 1'b0;
    logic [7:0] cmd_addr = '0;
    logic [7:0] cmd_wdata = '0;
    logic [2:0] cmd_len = '0;
    logic       rd_valid;
    logic [7:0] rd_data;
    logic       spi_sclk;
    logic       spi_mosi;
    logic       spi_miso = 1'b0;
    logic       spi_cs_n;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 0;

    always #2 clk = ~clk;

    spi_regbus_master #(.DIV_PRE(PRE), .DIV_EXP(EXP)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .cmd_len(cmd_len), .rd_valid(rd_valid), .rd_data(rd_data),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .spi_cs_n(spi_cs_n)
    );

    function automatic logic [7:0] slave_reg(input logic [7:0] a);
        return (a == 8'h0D) ? 8'h6A : 8'(a * 8'd7 + 8'h13);
    endfunction

    // slave model
    logic [7:0] mb [0:15];
    int         sbit = 0;
    logic [7:0] s_addr;
    int         rise_cyc = 0, last_rise = 0, per_meas = 0;
    int         cs_rise_cyc = 0, gap_meas = 0;

    always @(posedge clk) cyc = cyc + 1;

    always @(negedge spi_cs_n) begin
        sbit = 0;
        spi_miso = 1'b0;
        for (int i = 0; i < 16; i++) mb[i] = '0;
        gap_meas = cyc - cs_rise_cyc;
    end

    always @(posedge spi_cs_n) cs_rise_cyc = cyc;

    always @(posedge spi_sclk) begin
        per_meas  = cyc - last_rise;
        last_rise = cyc;
        if (!spi_cs_n && sbit < 128) begin
            mb[sbit/8] = {mb[sbit/8][6:0], spi_mosi};
            sbit = sbit + 1;
            if (sbit == 16) s_addr = {mb[1][7], mb[0][6:0]};
        end
    end

    always @(negedge spi_sclk) begin
        if (!spi_cs_n && sbit >= 16) begin
            logic [7:0] v;
            v = slave_reg(8'(s_addr + 8'((sbit - 16) / 8)));
            spi_miso = v[7 - ((sbit - 16) % 8)];
        end
    end

    // read byte monitor
    logic [7:0] rdbuf [0:15];
    int rdn = 0;
    always @(negedge clk) begin
        if (rd_valid && rdn < 16) begin
            rdbuf[rdn] = rd_data;
            rdn = rdn + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic send(input logic wr, input logic [7:0] a, input logic [7:0] wd,
                        input logic [2:0] len);
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        rdn = 0;
        cmd_valid = 1'b1; cmd_write = wr; cmd_addr = a; cmd_wdata = wd; cmd_len = len;
        @(negedge clk);
        cmd_valid = 1'b0;
        // R9: busy right after acceptance
        chk("R9 ready low after accept", {31'd0, cmd_ready}, 32'd0);
        chk("R9 cs low after accept", {31'd0, spi_cs_n}, 32'd0);
        while (!spi_cs_n) @(negedge clk);
        while (!cmd_ready) @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R1 cs_n", {31'd0, spi_cs_n}, 32'd1);
        chk("R1 sclk", {31'd0, spi_sclk}, 32'd0);
        chk("R1 mosi", {31'd0, spi_mosi}, 32'd0);
        chk("R1 ready", {31'd0, cmd_ready}, 32'd1);
        chk("R1 rd_valid", {31'd0, rd_valid}, 32'd0);
    endtask

    task automatic t_write(input logic [7:0] a, input logic [7:0] wd);
        send(1'b1, a, wd, 3'd0);
        chk("R6 write edge count", 32'(sbit), 32'd24);
        chk("R4 byte0", {24'd0, mb[0]}, {24'd0, 1'b1, a[6:0]});
        chk("R5 byte1", {24'd0, mb[1]}, {24'd0, a[7], 7'd0});
        chk("R6 write data byte", {24'd0, mb[2]}, {24'd0, wd});
        chk("R8 no read bytes on write", 32'(rdn), 32'd0);
        chk("R3 sclk period", 32'(per_meas), 32'(PERIOD_CLKS));
        chk("R2 sclk low when idle", {31'd0, spi_sclk}, 32'd0);
    endtask

    task automatic t_read(input logic [7:0] a, input logic [2:0] len);
        int nb;
        nb = int'(len) + 1;
        send(1'b0, a, 8'hFF, len);
        chk("R7 read edge count", 32'(sbit), 32'(8 * (3 + int'(len))));
        chk("R4 byte0 read", {24'd0, mb[0]}, {24'd0, 1'b0, a[6:0]});
        chk("R5 byte1 read", {24'd0, mb[1]}, {24'd0, a[7], 7'd0});
        for (int k = 0; k < nb; k++)
            chk("R7 mosi zero in data", {24'd0, mb[2 + k]}, 32'd0);
        chk("R8 read byte count", 32'(rdn), 32'(nb));
        for (int k = 0; k < nb && k < rdn; k++)
            chk("R8 read byte value", {24'd0, rdbuf[k]}, {24'd0, slave_reg(8'(a + 8'(k)))});
    endtask

    task automatic t_gap;
        t_write(8'h2A, 8'h55);
        t_write(8'h2B, 8'hAA);
        n_chk++;
        if (gap_meas < PERIOD_CLKS) begin
            n_bad++;
            $display("FAIL R10 cs high gap actual=%0d expected>=%0d", gap_meas, PERIOD_CLKS);
        end
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write(8'h3A, 8'h3D);
        t_write(8'hBC, 8'hC3);
        t_read(8'h0D, 3'd0);
        chk("R8 id byte", {24'd0, rdbuf[0]}, 32'h6A);
        t_read(8'h01, 3'd5);
        t_read(8'hFE, 3'd7);
        t_read(8'h80, 3'd0);
        t_gap();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule